// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction operand lives for a small 16-bit processor with eight general registers. Register 6 serves as the stack pointer and register 7 as the program counter. Each request carries a 4-bit addressing-mode code, a 3-bit register number, the extension word taken from the instruction stream, and a flag that marks a byte-sized operand. The caller also supplies the current contents of the named register and the current program counter value. One clock later the block gives one of four results: a memory address, a flag saying the operand is the register itself, a flag saying the operand is the immediate constant (with its value), or an illegal-mode flag.

For the post-increment and pre-decrement modes, the block also computes the new register value and presents it on a one-cycle write-back strobe. This strobe rises together with the address. The register moves by one for a byte operand and by two for a word operand. It always moves by two when the register is the stack pointer or the program counter, so those two stay word-aligned. Pre-decrement and post-increment on the stack pointer give a push and a pop. All address arithmetic wraps modulo 2^16.

Top module: `eag_top`

## Requirements
- R1: Mode code 0 (register operand) raises `opnd_reg` and produces no address and no write-back.
- R2: Mode code 1 (register indirect) gives an address equal to the register value and no write-back.
- R3: Mode code 4 (absolute) gives an address equal to the extension word, whatever the register number.
- R4: Mode code 5 (immediate) raises `opnd_imm`, drives `imm_value` with the extension word, and produces no address.
- R5: Mode code 6 (indexed) gives the extension word plus the register value, wrapping modulo 2^16.
- R6: Mode code 7 (PC-relative) gives `pc_value` plus the extension word, wrapping modulo 2^16.
- R7: Mode code 2 (post-increment) gives an address equal to the old register value. It writes back the register value plus the step to the same register number.
- R8: Mode code 3 (pre-decrement) gives the register value minus the step, wrapping modulo 2^16, as the address. It writes that same value back.
- R9: The step is 1 when `req_byte` is 1 and the register is 0 to 5. It is 2 for word operands, and 2 for registers 6 and 7 at either size.
- R10: `wb_en` is high for exactly one cycle per auto-modify request, in the cycle `ea_valid` is high, and never for other modes.
- R11: Mode codes 8 to 15 raise `mode_illegal` and produce no address, no operand flag and no write-back.
- R12: Results appear on the cycle after the request is sampled, and back-to-back requests give back-to-back results. Cycles without `req_valid` give all flags low. Reset clears every output even while a request is present, and at most one of the four result flags is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 4 | Addressing-mode code |
| req_reg | input | 3 | Register number |
| req_ext | input | 16 | Extension word (address, constant, base or offset) |
| req_byte | input | 1 | Operand is a byte |
| reg_value | input | 16 | Contents of register `req_reg` |
| pc_value | input | 16 | Current program counter |
| ea_valid | output | 1 | `ea_addr` holds an operand address |
| ea_addr | output | 16 | Effective address |
| opnd_reg | output | 1 | Operand is the register itself |
| opnd_imm | output | 1 | Operand is the immediate constant |
| imm_value | output | 16 | Immediate constant |
| mode_illegal | output | 1 | Unused mode code seen |
| wb_en | output | 1 | Register write-back strobe |
| wb_reg | output | 3 | Register to update |
| wb_value | output | 16 | Updated register value |

## Verification
Each mode is driven with register values and extension words chosen so that a wrong base or a missing offset would give a different address. Indexed, PC-relative and pre-decrement cases are also placed across the 16-bit wrap. The auto-modify modes are tried on a general register and on registers 6 and 7 at both operand sizes. This tells the size-based step apart from the forced word step, and shows whether the change is applied before or after the address is formed. Requests are issued back to back and with idle gaps, and one request is held during reset, to separate correct one-cycle timing from results that are stale or repeated.

// File: rtl/eag_pkg.sv
package eag_pkg;

    parameter int unsigned ADDR_W  = 16;
    parameter int unsigned REG_CNT = 8;
    parameter int unsigned MODE_W  = 4;
    parameter int unsigned SP_NUM  = 6;
    parameter int unsigned PC_NUM  = 7;

    localparam int unsigned REG_IDX_W = $clog2(REG_CNT);

    typedef enum logic [MODE_W-1:0] {
        AM_REG     = 4'd0,
        AM_IND     = 4'd1,
        AM_POSTINC = 4'd2,
        AM_PREDEC  = 4'd3,
        AM_DIRECT  = 4'd4,
        AM_IMMED   = 4'd5,
        AM_INDEX   = 4'd6,
        AM_PCREL   = 4'd7
    } amode_e;

    typedef enum logic [1:0] {
        BASE_ZERO = 2'd0,
        BASE_REG  = 2'd1,
        BASE_PC   = 2'd2
    } base_sel_e;

    typedef struct packed {
        logic      legal;
        logic      is_reg;
        logic      is_imm;
        logic      gen_addr;
        base_sel_e base;
        logic      add_ext;
        logic      pre_dec;
        logic      post_inc;
    } am_ctrl_t;

    function automatic logic is_auto(am_ctrl_t c);
        return c.pre_dec | c.post_inc;
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output am_ctrl_t          ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.legal = 1'b1;
        case (mode)
            AM_REG: begin
                ctrl.is_reg = 1'b1;
            end
            AM_IND: begin
                ctrl.gen_addr = 1'b1;
                ctrl.base     = BASE_REG;
            end
            AM_POSTINC: begin
                ctrl.gen_addr = 1'b1;
                ctrl.base     = BASE_REG;
                ctrl.post_inc = 1'b1;
            end
            AM_PREDEC: begin
                ctrl.gen_addr = 1'b1;
                ctrl.base     = BASE_REG;
                ctrl.pre_dec  = 1'b1;
            end
            AM_DIRECT: begin
                ctrl.gen_addr = 1'b1;
                ctrl.base     = BASE_ZERO;
                ctrl.add_ext  = 1'b1;
            end
            AM_IMMED: begin
                ctrl.is_imm = 1'b1;
            end
            AM_INDEX: begin
                ctrl.gen_addr = 1'b1;
                ctrl.base     = BASE_REG;
                ctrl.add_ext  = 1'b1;
            end
            AM_PCREL: begin
                ctrl.gen_addr = 1'b1;
                ctrl.base     = BASE_PC;
                ctrl.add_ext  = 1'b1;
            end
            default: begin
                ctrl.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eag_step.sv
module eag_step #(
    parameter int unsigned W       = 16,
    parameter int unsigned NREG    = 8,
    parameter int unsigned SP_IDX  = 6,
    parameter int unsigned PC_IDX  = 7,
    localparam int unsigned IDX_W  = $clog2(NREG)
) (
    input  logic             is_byte,
    input  logic [IDX_W-1:0] reg_idx,
    output logic [W-1:0]     step
);

    logic [NREG-1:0] word_only;

    for (genvar i = 0; i < NREG; i++) begin : g_mask
        assign word_only[i] = (i == SP_IDX) || (i == PC_IDX);
    end

    assign step = (is_byte && !word_only[reg_idx]) ? W'(1) : W'(2);

endmodule

// File: rtl/eag_addr.sv
module eag_addr
    import eag_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  base_sel_e    base,
    input  logic         add_ext,
    input  logic         pre_dec,
    input  logic         post_inc,
    input  logic [W-1:0] reg_val,
    input  logic [W-1:0] pc_val,
    input  logic [W-1:0] ext,
    input  logic [W-1:0] step,
    output logic [W-1:0] ea,
    output logic [W-1:0] new_reg
);

    logic [W-1:0] base_val;
    logic [W-1:0] ofs_val;
    logic [W-1:0] dec_val;
    logic [W-1:0] inc_val;

    always_comb begin
        case (base)
            BASE_REG: base_val = reg_val;
            BASE_PC:  base_val = pc_val;
            default:  base_val = '0;
        endcase
    end

    assign ofs_val = add_ext ? ext : '0;
    assign dec_val = reg_val - step;
    assign inc_val = reg_val + step;

    assign ea      = pre_dec ? dec_val : (base_val + ofs_val);
    assign new_reg = post_inc ? inc_val : dec_val;

endmodule

// File: rtl/eag_top.sv
module eag_top
    import eag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [3:0]  req_mode,
    input  logic [2:0]  req_reg,
    input  logic [15:0] req_ext,
    input  logic        req_byte,
    input  logic [15:0] reg_value,
    input  logic [15:0] pc_value,
    output logic        ea_valid,
    output logic [15:0] ea_addr,
    output logic        opnd_reg,
    output logic        opnd_imm,
    output logic [15:0] imm_value,
    output logic        mode_illegal,
    output logic        wb_en,
    output logic [2:0]  wb_reg,
    output logic [15:0] wb_value
);

    am_ctrl_t          ctrl;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] ea_calc;
    logic [ADDR_W-1:0] wb_calc;
    logic              take;

    eag_decode u_decode (
        .mode (req_mode),
        .ctrl (ctrl)
    );

    eag_step #(
        .W      (ADDR_W),
        .NREG   (REG_CNT),
        .SP_IDX (SP_NUM),
        .PC_IDX (PC_NUM)
    ) u_step (
        .is_byte (req_byte),
        .reg_idx (req_reg),
        .step    (step)
    );

    eag_addr #(
        .W (ADDR_W)
    ) u_addr (
        .base     (ctrl.base),
        .add_ext  (ctrl.add_ext),
        .pre_dec  (ctrl.pre_dec),
        .post_inc (ctrl.post_inc),
        .reg_val  (reg_value),
        .pc_val   (pc_value),
        .ext      (req_ext),
        .step     (step),
        .ea       (ea_calc),
        .new_reg  (wb_calc)
    );

    assign take = req_valid & ctrl.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_valid     <= 1'b0;
            ea_addr      <= '0;
            opnd_reg     <= 1'b0;
            opnd_imm     <= 1'b0;
            imm_value    <= '0;
            mode_illegal <= 1'b0;
            wb_en        <= 1'b0;
            wb_reg       <= '0;
            wb_value     <= '0;
        end else begin
            ea_valid     <= take & ctrl.gen_addr;
            ea_addr      <= (take & ctrl.gen_addr) ? ea_calc : '0;
            opnd_reg     <= take & ctrl.is_reg;
            opnd_imm     <= take & ctrl.is_imm;
            imm_value    <= (take & ctrl.is_imm) ? req_ext : '0;
            mode_illegal <= req_valid & ~ctrl.legal;
            wb_en        <= take & is_auto(ctrl);
            wb_reg       <= (take & is_auto(ctrl)) ? req_reg : '0;
            wb_value     <= (take & is_auto(ctrl)) ? wb_calc : '0;
        end
    end

endmodule

// File: rtl/eag_checker.sv
module eag_checker
    import eag_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [3:0]  req_mode,
    input logic [2:0]  req_reg,
    input logic [15:0] req_ext,
    input logic        req_byte,
    input logic [15:0] reg_value,
    input logic [15:0] pc_value,
    input logic        ea_valid,
    input logic [15:0] ea_addr,
    input logic        opnd_reg,
    input logic        opnd_imm,
    input logic [15:0] imm_value,
    input logic        mode_illegal,
    input logic        wb_en,
    input logic [2:0]  wb_reg,
    input logic [15:0] wb_value
);

    logic [15:0] exp_step;
    assign exp_step = (req_byte && (req_reg != 3'(SP_NUM)) && (req_reg != 3'(PC_NUM)))
                      ? 16'd1 : 16'd2;

    // R10
    wb_with_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> ea_valid);

    // R12
    one_result_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ea_valid, opnd_reg, opnd_imm, mode_illegal}));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(ea_valid || opnd_reg || opnd_imm || mode_illegal || wb_en));

    // R11
    illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode[3]) |=> (mode_illegal && !ea_valid && !wb_en));

    // R3
    absolute_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd4) |=> (ea_valid && ea_addr == $past(req_ext)));

    // R4
    immediate_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd5) |=> (opnd_imm && !ea_valid && imm_value == $past(req_ext)));

    // R6
    pc_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd7) |=>
            (ea_valid && 16'(ea_addr - $past(pc_value)) == $past(req_ext)));

    // R7
    post_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd2) |=>
            (wb_en && wb_reg == $past(req_reg) && ea_addr == $past(reg_value)
             && 16'(wb_value - ea_addr) == $past(exp_step)));

    // R8
    pre_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 4'd3) |=>
            (wb_en && wb_value == ea_addr
             && 16'($past(reg_value) - ea_addr) == $past(exp_step)));

endmodule

bind eag_top eag_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_mode     (req_mode),
    .req_reg      (req_reg),
    .req_ext      (req_ext),
    .req_byte     (req_byte),
    .reg_value    (reg_value),
    .pc_value     (pc_value),
    .ea_valid     (ea_valid),
    .ea_addr      (ea_addr),
    .opnd_reg     (opnd_reg),
    .opnd_imm     (opnd_imm),
    .imm_value    (imm_value),
    .mode_illegal (mode_illegal),
    .wb_en        (wb_en),
    .wb_reg       (wb_reg),
    .wb_value     (wb_value)
);

// File: tb/eag_top_test.sv
`timescale 1ns/1ps
module eag_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic [2:0]  req_reg = '0;
    logic [15:0] req_ext = '0;
    logic        req_byte = 1'b0;
    logic [15:0] reg_value = '0;
    logic [15:0] pc_value = '0;
    logic        ea_valid, opnd_reg, opnd_imm, mode_illegal, wb_en;
    logic [15:0] ea_addr, imm_value, wb_value;
    logic [2:0]  wb_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic        ea_v;
        logic [15:0] ea;
        logic        is_r;
        logic        is_i;
        logic [15:0] imm;
        logic        ill;
        logic        wb;
        logic [2:0]  wr;
        logic [15:0] wv;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    eag_top uut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_mode     (req_mode),
        .req_reg      (req_reg),
        .req_ext      (req_ext),
        .req_byte     (req_byte),
        .reg_value    (reg_value),
        .pc_value     (pc_value),
        .ea_valid     (ea_valid),
        .ea_addr      (ea_addr),
        .opnd_reg     (opnd_reg),
        .opnd_imm     (opnd_imm),
        .imm_value    (imm_value),
        .mode_illegal (mode_illegal),
        .wb_en        (wb_en),
        .wb_reg       (wb_reg),
        .wb_value     (wb_value)
    );

    function automatic exp_t model(logic [3:0] m, logic [2:0] r, logic [15:0] x,
                                   logic b, logic [15:0] rv, logic [15:0] pc, string tag);
        exp_t e;
        logic [15:0] st;
        e = '{1'b0, 16'h0, 1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 3'h0, 16'h0, tag};
        st = (b && r < 3'd6) ? 16'd1 : 16'd2;
        case (m)
            4'd0: e.is_r = 1'b1;
            4'd1: begin e.ea_v = 1'b1; e.ea = rv; end
            4'd2: begin e.ea_v = 1'b1; e.ea = rv; e.wb = 1'b1; e.wr = r; e.wv = rv + st; end
            4'd3: begin e.ea_v = 1'b1; e.ea = rv - st; e.wb = 1'b1; e.wr = r; e.wv = rv - st; end
            4'd4: begin e.ea_v = 1'b1; e.ea = x; end
            4'd5: begin e.is_i = 1'b1; e.imm = x; end
            4'd6: begin e.ea_v = 1'b1; e.ea = rv + x; end
            4'd7: begin e.ea_v = 1'b1; e.ea = pc + x; end
            default: e.ill = 1'b1;
        endcase
        return e;
    endfunction

    task automatic issue(input logic [3:0] m, input logic [2:0] r, input logic [15:0] x,
                         input logic b, input logic [15:0] rv, input logic [15:0] pc,
                         input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_mode  = m;
        req_reg   = r;
        req_ext   = x;
        req_byte  = b;
        reg_value = rv;
        pc_value  = pc;
        sb.push_back(model(m, r, x, b, rv, pc, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_mode  = 4'h0;
            req_ext   = 16'hDEAD;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ea_valid || opnd_reg || opnd_imm || mode_illegal) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12: unexpected result act=%b%b%b%b exp=none",
                             ea_valid, opnd_reg, opnd_imm, mode_illegal);
                end else begin
                    exp_t e;
                    logic ok;
                    e = sb.pop_front();
                    checks++;
                    ok = (ea_valid == e.ea_v) && (opnd_reg == e.is_r) && (opnd_imm == e.is_i)
                      && (mode_illegal == e.ill) && (wb_en == e.wb)
                      && (!e.ea_v || ea_addr == e.ea) && (!e.is_i || imm_value == e.imm)
                      && (!e.wb || (wb_reg == e.wr && wb_value == e.wv));
                    if (!ok) begin
                        errors++;
                        $display("FAIL %s: act v%b a%h r%b i%b/%h x%b w%b/%0d/%h exp v%b a%h r%b i%b/%h x%b w%b/%0d/%h",
                                 e.tag, ea_valid, ea_addr, opnd_reg, opnd_imm, imm_value,
                                 mode_illegal, wb_en, wb_reg, wb_value,
                                 e.ea_v, e.ea, e.is_r, e.is_i, e.imm, e.ill, e.wb, e.wr, e.wv);
                    end
                end
            end else if (wb_en) begin
                checks++; errors++;
                $display("FAIL R10: wb_en act=1 exp=0 with no address");
            end
        end
    end

    initial begin
        // R12: reset dominates a request that is present
        req_valid = 1'b1; req_mode = 4'd2; req_reg = 3'd1; reg_value = 16'h0040;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({ea_valid, opnd_reg, opnd_imm, mode_illegal, wb_en} != 5'b0 || ea_addr != 16'h0
            || wb_value != 16'h0) begin
            errors++;
            $display("FAIL R12: reset outputs act=%b%b%b%b%b/%h exp=00000/0000",
                     ea_valid, opnd_reg, opnd_imm, mode_illegal, wb_en, ea_addr);
        end
        req_valid = 1'b0;
        rst = 1'b0;
        idle(2);

        issue(4'd0, 3'd3, 16'h1111, 1'b0, 16'h5555, 16'h0100, "R1 register");
        issue(4'd1, 3'd2, 16'h2222, 1'b0, 16'h1234, 16'h0100, "R2 indirect");
        issue(4'd4, 3'd5, 16'hBEEF, 1'b1, 16'h7777, 16'h0100, "R3 absolute");
        issue(4'd5, 3'd0, 16'h0042, 1'b0, 16'h3333, 16'h0100, "R4 immediate");
        idle(1);
        issue(4'd6, 3'd1, 16'h0020, 1'b0, 16'h0100, 16'h0100, "R5 indexed");
        issue(4'd6, 3'd4, 16'h0020, 1'b0, 16'hFFF0, 16'h0100, "R5 indexed wrap");
        issue(4'd7, 3'd2, 16'hFFFE, 1'b0, 16'h9999, 16'h1000, "R6 pc-relative back");
        issue(4'd7, 3'd0, 16'h0010, 1'b0, 16'h9999, 16'hFFF8, "R6 pc-relative wrap");
        idle(2);
        issue(4'd2, 3'd0, 16'h0000, 1'b1, 16'h0010, 16'h0100, "R7 R9 postinc byte");
        issue(4'd2, 3'd0, 16'h0000, 1'b0, 16'h0010, 16'h0100, "R7 R9 postinc word");
        issue(4'd2, 3'd6, 16'h0000, 1'b1, 16'h0200, 16'h0100, "R7 R9 pop sp byte");
        issue(4'd2, 3'd7, 16'h0000, 1'b1, 16'h0300, 16'h0100, "R7 R9 postinc pc byte");
        issue(4'd3, 3'd1, 16'h0000, 1'b1, 16'h0020, 16'h0100, "R8 R9 predec byte");
        issue(4'd3, 3'd6, 16'h0000, 1'b0, 16'h0000, 16'h0100, "R8 R10 push sp wrap");
        issue(4'd3, 3'd6, 16'h0000, 1'b1, 16'h0400, 16'h0100, "R8 R9 push sp byte");
        issue(4'd3, 3'd5, 16'h0000, 1'b0, 16'h0001, 16'h0100, "R8 predec word wrap");
        idle(1);
        issue(4'd8, 3'd2, 16'h1234, 1'b0, 16'h0050, 16'h0100, "R11 code 8");
        issue(4'd15, 3'd6, 16'h1234, 1'b0, 16'h0050, 16'h0100, "R11 code 15");
        issue(4'd1, 3'd6, 16'h0000, 1'b0, 16'h0ACE, 16'h0100, "R10 indirect no wb");
        idle(3);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R12: missing results act=%0d exp=0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R12: watchdog act=hung exp=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule